// File: doc/BRIEF.md
# Microcoded Instruction Sequencer

This block is the control state machine of a small 16-bit load/store processor whose registers, ALU, address adder and memory all share one bus. On every clock it emits one control word: register load enables, one bus gate enable, mux selects, the ALU operation, and the memory enable and write lines. It fetches an instruction, decodes it, and steps through the execute states of five instructions. The datapath registers and the memory array sit outside the block and follow the control word.

The sequencer implements five instructions:

- an increment by a signed 9-bit immediate, which goes through the address adder;
- a condition-code set from a register;
- a PC-relative jump with an 11-bit offset;
- a load from the address formed by inverting a register;
- a store of a register at the current PC.

The last two share one opcode and are told apart by the lowest instruction bit. Every state that touches memory waits for a ready flag. An opcode with no meaning parks the sequencer in a halt state until reset.

Top module: `ucode_seq`

## Requirements
- R1: A synchronous, active-high `rst` sets the state to 0 (fetch-address) and holds it there while asserted.
- R2: Fetch runs through these states:
  - state 0 asserts `gate_pc`, `ld_mar` and `ld_pc` with `pc_sel`=0;
  - state 1 asserts `mem_en` and `ld_mdr`;
  - state 2 asserts `gate_mdr` and `ld_ir`;
  - state 3 (decode) asserts nothing.
- R3: At most one of `gate_pc`, `gate_mdr`, `gate_alu`, `gate_adr` is high in any state, and `ld_ir` is high only in state 2. Every signal not listed for a state is 0.
- R4: With `ir[15:12]`=0001, decode goes to state 4. State 4 sets:
  - `sr1_sel`=0, `a1_sel`=1, `a2_sel`=2, `ma_sel`=1 and `dr_sel`=0;
  - `gate_adr`, `ld_reg` and `ld_cc`.
- R5: With `ir[15:12]`=0101, decode goes to state 5. State 5 sets `sr1_sel`=0 and `alu_op`=3 (pass), with `gate_alu` and `ld_cc`. It writes no register.
- R6: With `ir[15:12]`=1100 and `ir[11]`=0, decode goes to state 6. State 6 asserts `ld_pc` with `pc_sel`=1, `a1_sel`=0 and `a2_sel`=3, and gates nothing onto the bus. With `ir[11]`=1 the sequencer halts instead.
- R7: With `ir[15:12]`=1101 and `ir[0]`=1 (inverted-address load), the sequencer runs three states:
  - state 7 sets `sr1_sel`=1 and `alu_op`=2 (invert), with `gate_alu` and `ld_mar`;
  - state 8 asserts `mem_en` and `ld_mdr`;
  - state 9 asserts `gate_mdr`, `ld_reg` and `ld_cc` with `dr_sel`=0.
- R8: With `ir[15:12]`=1101 and `ir[0]`=0 (store at PC), the sequencer runs three states:
  - state 10 asserts `gate_pc` and `ld_mar`;
  - state 11 sets `sr1_sel`=0 and `alu_op`=3, with `gate_alu` and `ld_mdr`;
  - state 12 asserts `mem_en` and `mem_wr`.
- R9: States 1, 8 and 12 repeat their control word for as long as `mem_rdy` is low, and advance on the first edge at which it is high.
- R10: Any other opcode leads to state 15 (halt). That state asserts no signal and stays until reset, whatever `mem_rdy` does.
- R11: After the last state of each instruction (4, 5, 6, 9 or 12 when ready), the next state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 16 | Instruction register contents |
| mem_rdy | input | 1 | Memory has completed the current access |
| ld_mar | output | 1 | Load memory address register |
| ld_mdr | output | 1 | Load memory data register |
| ld_ir | output | 1 | Load instruction register |
| ld_reg | output | 1 | Write the destination register |
| ld_cc | output | 1 | Load condition codes from the bus |
| ld_pc | output | 1 | Load program counter |
| gate_pc | output | 1 | Drive PC onto the bus |
| gate_mdr | output | 1 | Drive MDR onto the bus |
| gate_alu | output | 1 | Drive ALU result onto the bus |
| gate_adr | output | 1 | Drive address mux onto the bus |
| pc_sel | output | 2 | PC source: 0 increment, 1 adder, 2 bus |
| dr_sel | output | 1 | Destination: 0 ir[11:9], 1 register 7 |
| sr1_sel | output | 1 | Source 1: 0 ir[11:9], 1 ir[8:6] |
| a1_sel | output | 1 | Adder base: 0 PC, 1 source 1 |
| a2_sel | output | 2 | Adder offset: 0 zero, 1 6-bit, 2 9-bit, 3 11-bit sign-extended |
| ma_sel | output | 1 | Address mux: 0 zero-extended byte, 1 adder |
| alu_op | output | 2 | ALU: 0 add, 1 and, 2 invert, 3 pass |
| mem_en | output | 1 | Memory access enable |
| mem_wr | output | 1 | Memory write (1) or read (0) |
| state | output | 4 | Current sequencer state |

## Verification
The control word is a pure function of the state, so each expected word belongs to exactly one clock period. It is due in the cycle that follows the edge that entered that state. One register lies between an input and the word it selects: the decode opcode and `mem_rdy` act at the closing edge of a state and show up one cycle later. The driver queues one expected word per cycle and changes inputs just after a rising edge. The monitor compares at the falling edge, so it never samples across the edge where the state moves. Memory waits of zero to three cycles move every later expectation by exactly that many entries.

// File: rtl/ucode_seq.sv
module ucode_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] ir,
  input  logic        mem_rdy,
  output logic        ld_mar,
  output logic        ld_mdr,
  output logic        ld_ir,
  output logic        ld_reg,
  output logic        ld_cc,
  output logic        ld_pc,
  output logic        gate_pc,
  output logic        gate_mdr,
  output logic        gate_alu,
  output logic        gate_adr,
  output logic [1:0]  pc_sel,
  output logic        dr_sel,
  output logic        sr1_sel,
  output logic        a1_sel,
  output logic [1:0]  a2_sel,
  output logic        ma_sel,
  output logic [1:0]  alu_op,
  output logic        mem_en,
  output logic        mem_wr,
  output logic [3:0]  state
);
  typedef enum logic [3:0] {
    S_F0 = 4'd0, S_F1 = 4'd1, S_F2 = 4'd2, S_DEC = 4'd3,
    S_INC = 4'd4, S_SET = 4'd5, S_JMP = 4'd6,
    S_L0 = 4'd7, S_L1 = 4'd8, S_L2 = 4'd9,
    S_I0 = 4'd10, S_I1 = 4'd11, S_I2 = 4'd12,
    S_HALT = 4'd15
  } st_t;

  st_t st, nx;
  logic unused_ir;
  assign unused_ir = ^ir[10:1];
  assign state = st;

  always_ff @(posedge clk)
    if (rst) st <= S_F0;
    else     st <= nx;

  always_comb begin
    nx = st;
    case (st)
      S_F0:  nx = S_F1;
      S_F1:  if (mem_rdy) nx = S_F2;
      S_F2:  nx = S_DEC;
      S_DEC:
        case (ir[15:12])
          4'b0001: nx = S_INC;
          4'b0101: nx = S_SET;
          4'b1100: nx = ir[11] ? S_HALT : S_JMP;
          4'b1101: nx = ir[0] ? S_L0 : S_I0;
          default: nx = S_HALT;
        endcase
      S_INC, S_SET, S_JMP, S_L2: nx = S_F0;
      S_L0:  nx = S_L1;
      S_L1:  if (mem_rdy) nx = S_L2;
      S_I0:  nx = S_I1;
      S_I1:  nx = S_I2;
      S_I2:  if (mem_rdy) nx = S_F0;
      default: nx = S_HALT;
    endcase
  end

  always_comb begin
    {ld_mar, ld_mdr, ld_ir, ld_reg, ld_cc, ld_pc} = '0;
    {gate_pc, gate_mdr, gate_alu, gate_adr} = '0;
    {pc_sel, dr_sel, sr1_sel, a1_sel, a2_sel, ma_sel, alu_op} = '0;
    {mem_en, mem_wr} = '0;
    case (st)
      S_F0:  begin gate_pc = 1'b1; ld_mar = 1'b1; ld_pc = 1'b1; end
      S_F1:  begin mem_en = 1'b1; ld_mdr = 1'b1; end
      S_F2:  begin gate_mdr = 1'b1; ld_ir = 1'b1; end
      S_INC: begin
        a1_sel = 1'b1; a2_sel = 2'd2; ma_sel = 1'b1;
        gate_adr = 1'b1; ld_reg = 1'b1; ld_cc = 1'b1;
      end
      S_SET: begin alu_op = 2'd3; gate_alu = 1'b1; ld_cc = 1'b1; end
      S_JMP: begin ld_pc = 1'b1; pc_sel = 2'd1; a2_sel = 2'd3; end
      S_L0:  begin sr1_sel = 1'b1; alu_op = 2'd2; gate_alu = 1'b1; ld_mar = 1'b1; end
      S_L1:  begin mem_en = 1'b1; ld_mdr = 1'b1; end
      S_L2:  begin gate_mdr = 1'b1; ld_reg = 1'b1; ld_cc = 1'b1; end
      S_I0:  begin gate_pc = 1'b1; ld_mar = 1'b1; end
      S_I1:  begin alu_op = 2'd3; gate_alu = 1'b1; ld_mdr = 1'b1; end
      S_I2:  begin mem_en = 1'b1; mem_wr = 1'b1; end
      default: ;
    endcase
  end

  a_r3_one_gate: assert property (@(posedge clk) disable iff (rst)
    $countones({gate_pc, gate_mdr, gate_alu, gate_adr}) <= 1);
  a_r3_ir_in_fetch: assert property (@(posedge clk) disable iff (rst)
    ld_ir |-> state == 4'd2);
  a_r2_decode_follows: assert property (@(posedge clk) disable iff (rst)
    ld_ir |=> state == 4'd3);
  a_r9_mem_wait: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_rdy) |=> $stable(state));
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    state == 4'd15 |=> state == 4'd15);
  a_r10_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    state == 4'd15 |-> !(ld_mar || ld_mdr || ld_ir || ld_reg || ld_cc || ld_pc || mem_en));
  a_r11_cc_then_fetch: assert property (@(posedge clk) disable iff (rst)
    ld_cc |=> state == 4'd0);
endmodule

// File: tb/test_ucode_seq.sv
`timescale 1ns/100ps
module test_ucode_seq;
  logic clk = 1'b0, rst = 1'b1, mem_rdy = 1'b0;
  logic [15:0] ir = '0;
  logic ld_mar, ld_mdr, ld_ir, ld_reg, ld_cc, ld_pc;
  logic gate_pc, gate_mdr, gate_alu, gate_adr;
  logic [1:0] pc_sel, a2_sel, alu_op;
  logic dr_sel, sr1_sel, a1_sel, ma_sel, mem_en, mem_wr;
  logic [3:0] state;

  ucode_seq i_ucode_seq (.*);

  always #2.5 clk = ~clk;

  localparam logic [25:0] LDMAR = 26'h1 << 25, LDMDR = 26'h1 << 24, LDIR = 26'h1 << 23,
    LDREG = 26'h1 << 22, LDCC = 26'h1 << 21, LDPC = 26'h1 << 20, GPC = 26'h1 << 19,
    GMDR = 26'h1 << 18, GALU = 26'h1 << 17, GADR = 26'h1 << 16, SR1 = 26'h1 << 12,
    A1 = 26'h1 << 11, MA = 26'h1 << 8, MEN = 26'h1 << 5, MWR = 26'h1 << 4;
  localparam logic [25:0] EF0 = LDMAR | LDPC | GPC | 26'd0;
  localparam logic [25:0] EF1 = MEN | LDMDR | 26'd1;
  localparam logic [25:0] EF2 = GMDR | LDIR | 26'd2;
  localparam logic [25:0] EDEC = 26'd3;
  localparam logic [25:0] EINC = GADR | LDREG | LDCC | MA | A1 | (26'd2 << 9) | 26'd4;
  localparam logic [25:0] ESET = GALU | LDCC | (26'd3 << 6) | 26'd5;
  localparam logic [25:0] EJMP = LDPC | (26'd1 << 14) | (26'd3 << 9) | 26'd6;
  localparam logic [25:0] EL0 = GALU | LDMAR | SR1 | (26'd2 << 6) | 26'd7;
  localparam logic [25:0] EL1 = MEN | LDMDR | 26'd8;
  localparam logic [25:0] EL2 = GMDR | LDREG | LDCC | 26'd9;
  localparam logic [25:0] EI0 = GPC | LDMAR | 26'd10;
  localparam logic [25:0] EI1 = GALU | LDMDR | (26'd3 << 6) | 26'd11;
  localparam logic [25:0] EI2 = MEN | MWR | 26'd12;
  localparam logic [25:0] EH = 26'd15;

  wire [25:0] act = {ld_mar, ld_mdr, ld_ir, ld_reg, ld_cc, ld_pc, gate_pc, gate_mdr,
                     gate_alu, gate_adr, pc_sel, dr_sel, sr1_sel, a1_sel, a2_sel, ma_sel,
                     alu_op, mem_en, mem_wr, state};

  typedef struct { logic [25:0] w; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;

  task automatic step(input logic [25:0] w, input string tag);
    item_t it;
    it.w = w; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic memwait(input logic [25:0] w, input int waits, input string tag);
    repeat (waits) step(w, "R9");
    mem_rdy = 1'b1;
    step(w, tag);
    mem_rdy = 1'b0;
  endtask

  task automatic fetch(input logic [15:0] iv, input int waits, input string tag);
    step(EF0, tag);
    memwait(EF1, waits, "R2");
    ir = iv;
    step(EF2, "R3");
    step(EDEC, "R2");
  endtask

  always @(negedge clk) begin : monitor
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (act !== it.w) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.w);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk); @(posedge clk); #1;
    step(EF0, "R1");
    rst = 1'b0;
    fetch(16'h17FF, 0, "R2");        step(EINC, "R4");
    fetch(16'h5C00, 2, "R11");       step(ESET, "R5");
    fetch(16'hC3FF, 1, "R11");       step(EJMP, "R6");
    fetch(16'hD1FF, 0, "R11");       step(EL0, "R7"); memwait(EL1, 3, "R7"); step(EL2, "R7");
    fetch(16'hDA00, 1, "R11");       step(EI0, "R8"); step(EI1, "R8"); memwait(EI2, 2, "R8");
    fetch(16'h1E40, 0, "R11");       step(EINC, "R4");
    fetch(16'h0000, 0, "R11");       step(EH, "R10");
    repeat (3) step(EH, "R10");
    mem_rdy = 1'b1; step(EH, "R10"); mem_rdy = 1'b0;
    rst = 1'b1; step(EH, "R10");
    step(EF0, "R1");
    rst = 1'b0;
    fetch(16'hC800, 0, "R2");        step(EH, "R6"); step(EH, "R10");
    rst = 1'b1; step(EH, "R10"); step(EF0, "R1"); rst = 1'b0;
    fetch(16'hF000, 0, "R2");        step(EH, "R10");
    @(negedge clk); #1;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2 actual %0d expected 0 pending", q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule